// File: doc/BRIEF.md
# Barrel-Pipeline Thread Issue Selector

This block decides, once per clock, which hardware thread context may send a fetch into a barrel-style pipeline. Each thread has its own program counter register. A thread may have only one instruction in the pipeline at a time. After a thread issues, it stays out of selection until writeback reports that the instruction has finished. Because of this, the pipeline needs no dependency checking and no branch prediction between instructions of the same thread.

Each thread is either in the ready pool or in the waiting pool. A per-thread park pulse, such as a long memory miss, moves a thread into the waiting pool. A per-thread wake pulse moves it back. Among the threads that are ready and have nothing in flight, a round-robin pointer picks the next one, starting just after the last thread that issued. The completion pulse carries the resolved next PC, which covers a branch target or the sequential address, and that value becomes the thread's new PC. When no thread can issue, the fetch slot stays empty for that cycle.

Top module: `tsel_top`

## Requirements
- R1: While reset is high and in the first cycle after reset, no thread is busy or parked. The selector offers thread 0 with fetch valid high. Thread i's PC resets to BOOT_PC + i*BOOT_STRIDE (defaults 0x1000 and 0x100).
- R2: A thread that issues is not offered again until a completion for that thread has been accepted.
- R3: When several threads are eligible, the selector offers the first eligible thread in ascending ID order starting at last-issued ID + 1, wrapping from NUM_THREADS-1 to 0.
- R4: A completion for a thread that has an instruction in flight writes done_pc_i into that thread's PC. The thread can be offered in the very next cycle, with the new PC on fetch_pc_o.
- R5: A completion for a thread that has no instruction in flight is ignored. That thread's PC is left unchanged.
- R6: A park pulse places a thread in the waiting pool. A parked thread is never offered, even after its completion, until a wake pulse arrives. When park and wake arrive in the same cycle, park takes effect.
- R7: fetch_valid_o is low in every cycle in which no thread is both ready and free of an in-flight instruction.
- R8: Two consecutive issues never come from the same thread.
- R9: With NUM_THREADS ready threads and each completion returned NUM_THREADS-1 cycles after its fetch, fetch_valid_o stays high every cycle. The thread IDs rotate 0,1,...,NUM_THREADS-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| park_i | input | NUM_THREADS | Per-thread pulse: move the thread to the waiting pool |
| wake_i | input | NUM_THREADS | Per-thread pulse: return the thread to the ready pool |
| done_valid_i | input | 1 | Completion pulse from writeback |
| done_tid_i | input | clog2(NUM_THREADS) | Thread ID of the completing instruction |
| done_pc_i | input | PC_W | Resolved next PC for that thread |
| fetch_valid_o | output | 1 | A thread issues this cycle |
| fetch_tid_o | output | clog2(NUM_THREADS) | ID of the issuing thread |
| fetch_pc_o | output | PC_W | PC of the issuing thread |

## Verification
The hardest case to reach is a choice between two or more eligible threads. The block issues a ready thread every cycle, so after reset the pool drains at once, and normally only one thread becomes free at a time. The stimulus gets around this by parking a busy thread and completing it while it stays parked. In one cycle it then releases the thread with a wake pulse and completes a second thread, so two threads become eligible together. Using this, the bench checks the round-robin order both with and without wrap-around. It also checks that a completion for a parked thread that is not in flight leaves its PC unchanged.

// File: rtl/tsel_pkg.sv
package tsel_pkg;

    // Per-thread scheduling flags.
    typedef struct packed {
        logic busy;    // one instruction of this thread is in the pipeline
        logic parked;  // thread sits in the waiting pool
    } thr_flags_t;

    function automatic logic may_issue(thr_flags_t f);
        return !f.busy && !f.parked;
    endfunction

endpackage

// File: rtl/tsel_ctx.sv
module tsel_ctx
    import tsel_pkg::*;
#(
    parameter int              PC_W    = 32,
    parameter logic [PC_W-1:0] BOOT_PC = '0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            issue,
    input  logic            park,
    input  logic            wake,
    input  logic            done,
    input  logic [PC_W-1:0] done_pc,
    output logic            eligible,
    output logic [PC_W-1:0] pc
);

    thr_flags_t flags;

    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
            pc    <= BOOT_PC;
        end else begin
            if (issue) begin
                flags.busy <= 1'b1;
            end else if (done && flags.busy) begin
                flags.busy <= 1'b0;
                pc         <= done_pc;
            end
            if (park) begin
                flags.parked <= 1'b1;
            end else if (wake) begin
                flags.parked <= 1'b0;
            end
        end
    end

    assign eligible = may_issue(flags);

    // R2: the arbiter only grants a thread that is free to issue
    a_r2_grant_eligible: assert property (@(posedge clk) disable iff (rst)
        issue |-> eligible);

    // R2: once issued, the thread drops out of selection
    a_r2_busy_after_issue: assert property (@(posedge clk) disable iff (rst)
        issue |=> !eligible);

    // R5: a completion without an instruction in flight leaves the PC alone
    a_r5_stray_done_ignored: assert property (@(posedge clk) disable iff (rst)
        (done && !flags.busy) |=> pc == $past(pc));

    // R6: parked threads are never granted
    a_r6_parked_not_granted: assert property (@(posedge clk) disable iff (rst)
        flags.parked |-> !issue);

endmodule

// File: rtl/tsel_rr_arb.sv
module tsel_rr_arb #(
    parameter int NUM_THREADS = 8,
    localparam int TW = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
    input  logic [NUM_THREADS-1:0] elig,
    input  logic [TW-1:0]          last,
    output logic                   grant_valid,
    output logic [TW-1:0]          grant_tid
);

    always_comb begin
        grant_valid = 1'b0;
        grant_tid   = '0;
        // Scan from the farthest offset down so the nearest eligible one wins.
        for (int k = NUM_THREADS - 1; k >= 0; k--) begin
            int idx;
            idx = (int'(last) + 1 + k) % NUM_THREADS;
            if (elig[idx]) begin
                grant_valid = 1'b1;
                grant_tid   = TW'(idx);
            end
        end
    end

endmodule

// File: rtl/tsel_top.sv
module tsel_top
    import tsel_pkg::*;
#(
    parameter int              NUM_THREADS = 8,
    parameter int              PC_W        = 32,
    parameter logic [PC_W-1:0] BOOT_PC     = PC_W'(32'h0000_1000),
    parameter logic [PC_W-1:0] BOOT_STRIDE = PC_W'(32'h0000_0100)
) (
    input  logic                                                 clk,
    input  logic                                                 rst,
    input  logic [NUM_THREADS-1:0]                               park_i,
    input  logic [NUM_THREADS-1:0]                               wake_i,
    input  logic                                                 done_valid_i,
    input  logic [((NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1)-1:0] done_tid_i,
    input  logic [PC_W-1:0]                                      done_pc_i,
    output logic                                                 fetch_valid_o,
    output logic [((NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1)-1:0] fetch_tid_o,
    output logic [PC_W-1:0]                                      fetch_pc_o
);

    localparam int TW = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1;

    logic [NUM_THREADS-1:0] elig;
    logic [NUM_THREADS-1:0] issue_vec;
    logic [PC_W-1:0]        pc_bank [NUM_THREADS];
    logic [TW-1:0]          last_tid;
    logic                   grant_valid;
    logic [TW-1:0]          grant_tid;
    logic                   issuing;

    assign issuing = grant_valid && !rst;

    for (genvar i = 0; i < NUM_THREADS; i++) begin : g_ctx
        assign issue_vec[i] = issuing && (grant_tid == TW'(i));

        tsel_ctx #(
            .PC_W    (PC_W),
            .BOOT_PC (BOOT_PC + PC_W'(i) * BOOT_STRIDE)
        ) u_ctx (
            .clk      (clk),
            .rst      (rst),
            .issue    (issue_vec[i]),
            .park     (park_i[i]),
            .wake     (wake_i[i]),
            .done     (done_valid_i && (done_tid_i == TW'(i))),
            .done_pc  (done_pc_i),
            .eligible (elig[i]),
            .pc       (pc_bank[i])
        );
    end

    tsel_rr_arb #(
        .NUM_THREADS (NUM_THREADS)
    ) u_arb (
        .elig        (elig),
        .last        (last_tid),
        .grant_valid (grant_valid),
        .grant_tid   (grant_tid)
    );

    // Reset to the top ID so that the first grant goes to thread 0.
    always_ff @(posedge clk) begin
        if (rst) begin
            last_tid <= TW'(NUM_THREADS - 1);
        end else if (grant_valid) begin
            last_tid <= grant_tid;
        end
    end

    assign fetch_valid_o = grant_valid;
    assign fetch_tid_o   = grant_tid;
    assign fetch_pc_o    = pc_bank[grant_tid];

    // R7: an idle slot only when the ready pool has nobody free
    a_r7_idle_only_when_empty: assert property (@(posedge clk) disable iff (rst)
        !fetch_valid_o |-> elig == '0);

    // R8: consecutive issues come from different threads
    a_r8_switch_thread: assert property (@(posedge clk) disable iff (rst)
        (fetch_valid_o && $past(fetch_valid_o && !rst)) |-> fetch_tid_o != $past(fetch_tid_o));

    // R2: at most one grant per cycle
    a_r2_single_grant: assert property (@(posedge clk) disable iff (rst)
        $onehot0(issue_vec));

endmodule

// File: tb/tsel_top_test.sv
module tsel_top_test;

    localparam int N  = 8;
    localparam int TW = 3;
    localparam int PW = 32;

    logic          clk = 1'b0;
    logic          rst;
    logic [N-1:0]  park_i;
    logic [N-1:0]  wake_i;
    logic          done_valid_i;
    logic [TW-1:0] done_tid_i;
    logic [PW-1:0] done_pc_i;
    logic          fetch_valid_o;
    logic [TW-1:0] fetch_tid_o;
    logic [PW-1:0] fetch_pc_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    tsel_top #(.NUM_THREADS(N), .PC_W(PW)) uut (
        .clk(clk), .rst(rst), .park_i(park_i), .wake_i(wake_i),
        .done_valid_i(done_valid_i), .done_tid_i(done_tid_i), .done_pc_i(done_pc_i),
        .fetch_valid_o(fetch_valid_o), .fetch_tid_o(fetch_tid_o), .fetch_pc_o(fetch_pc_o)
    );

    function automatic logic [PW-1:0] boot(int t);
        return 32'h1000 + 32'(t) * 32'h100;
    endfunction

    task automatic check(string req, logic [PW-1:0] act, logic [PW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic expect_fetch(string req, int tid, logic [PW-1:0] pc);
        check({req, " valid"}, 32'(fetch_valid_o), 32'd1);
        check({req, " tid"}, 32'(fetch_tid_o), 32'(tid));
        check({req, " pc"}, fetch_pc_o, pc);
    endtask

    task automatic expect_idle(string req);
        check({req, " idle"}, 32'(fetch_valid_o), 32'd0);
    endtask

    // Apply the currently driven inputs at the next edge, then clear pulses.
    task automatic tick();
        @(negedge clk);
        park_i       = '0;
        wake_i       = '0;
        done_valid_i = 1'b0;
        done_tid_i   = '0;
        done_pc_i    = '0;
    endtask

    task automatic complete(int tid, logic [PW-1:0] pc);
        done_valid_i = 1'b1;
        done_tid_i   = TW'(tid);
        done_pc_i    = pc;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        tick();
        tick();
        rst = 1'b0;
    endtask

    // R1, R3, R8, R7: reset state, then the pool drains in ID order
    task automatic t_reset_and_drain();
        do_reset();
        expect_fetch("R1 reset", 0, boot(0));
        for (int k = 0; k < N; k++) begin
            expect_fetch("R3/R8 rotate", k, boot(k));
            tick();
        end
        expect_idle("R7 all busy");
        tick();
        expect_idle("R7 still busy");
    endtask

    // R4, R2: completion makes a thread eligible with the new PC
    task automatic t_complete();
        complete(5, 32'h5550);
        tick();
        expect_fetch("R4 done reissue", 5, 32'h5550);
        tick();
        expect_idle("R2 no reissue before done");
    endtask

    // R6, R5, R3: waiting pool, stray completion, round-robin choice
    task automatic t_park_and_order();
        park_i[3] = 1'b1;
        tick();
        complete(3, 32'h3330);
        tick();
        expect_idle("R6 parked after done");
        complete(3, 32'hDEAD);
        tick();
        expect_idle("R5 stray done");
        complete(1, 32'h1110);
        tick();
        expect_fetch("R4 thread1", 1, 32'h1110);
        tick();
        expect_idle("R7 after t1");
        wake_i[3] = 1'b1;
        complete(6, 32'h6660);
        tick();
        expect_fetch("R3 pick after last=1", 3, 32'h3330);
        tick();
        expect_fetch("R3 second pick", 6, 32'h6660);
        tick();
        expect_idle("R7 after pair");
        // wrap-around: last=6, eligible {2,7}
        park_i[2] = 1'b1;
        tick();
        complete(2, 32'h2220);
        tick();
        expect_idle("R6 parked t2");
        wake_i[2] = 1'b1;
        complete(7, 32'h7770);
        tick();
        expect_fetch("R3 wrap first", 7, 32'h7770);
        tick();
        expect_fetch("R3 wrap second", 2, 32'h2220);
        tick();
        expect_idle("R7 after wrap");
        // park and wake together: park wins
        park_i[4] = 1'b1;
        wake_i[4] = 1'b1;
        tick();
        complete(4, 32'h4440);
        tick();
        expect_idle("R6 park beats wake");
        wake_i[4] = 1'b1;
        tick();
        expect_fetch("R6 woken", 4, 32'h4440);
        tick();
        expect_idle("R7 after wake");
    endtask

    // R9: completions N-1 cycles after fetch keep the slot full
    task automatic t_pipeline();
        logic [PW-1:0] hist_pc [48];
        int            hist_tid [48];
        do_reset();
        for (int c = 0; c < 48; c++) begin
            check("R9 valid", 32'(fetch_valid_o), 32'd1);
            check("R9 tid", 32'(fetch_tid_o), 32'(c % N));
            check("R9 pc", fetch_pc_o, boot(c % N) + 32'(4 * (c / N)));
            hist_pc[c]  = fetch_pc_o;
            hist_tid[c] = int'(fetch_tid_o);
            if (c >= N - 1) complete(hist_tid[c-(N-1)], hist_pc[c-(N-1)] + 32'd4);
            tick();
        end
    endtask

    initial begin
        rst          = 1'b1;
        park_i       = '0;
        wake_i       = '0;
        done_valid_i = 1'b0;
        done_tid_i   = '0;
        done_pc_i    = '0;
        @(negedge clk);
        t_reset_and_drain();
        t_complete();
        t_park_and_order();
        t_pipeline();
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule